// File: doc/BRIEF.md
# Sliding 3x3 Window Rank Sorter

This block holds the nine pixels of a 3x3 image neighbourhood as a list sorted from largest to smallest. Each accepted update slides the window by one column. The three pixels of the column that has been in the window longest are dropped, and a fresh column of three pixels is merged in. The new list is ready at the clock edge that captures the column.

The list that is already sorted is not rebuilt. Each stored entry works out its new place from two counts: the surviving entries ahead of it and the incoming pixels strictly larger than it. Each incoming pixel works out its place from its rank inside its own column and the number of survivors that are greater than or equal to it. Every entry carries a column tag. The tag that marks the oldest column advances by one on each update, so retiring a column needs no shifting.

A downstream rank or median filter reads the sorted list or the median tap. The column feed, from line buffers, and the handling of image borders belong outside this block.

Top module: `wsort_win3x3`

## Requirements
- R1: While reset is applied, and after it is released, all nine sorted outputs and the median read 0 and `out_valid` is 0.
- R2: On a clock edge with `in_valid` high, the stored set becomes exactly the nine pixels of the three most recently accepted columns. Before three columns have been accepted, zero-valued entries stand in for the missing columns.
- R3: At all times, the sorted outputs are in non-increasing order from position 0 to position 8. Equal values are kept, including all nine equal.
- R4: On a clock edge with `in_valid` low, the stored set does not change, no column is retired, and the column input has no effect.
- R5: `out_valid` rises at the clock edge that accepts the third column after reset. It then stays high until the next reset.
- R6: `out_median` equals sorted position 4, the fifth largest of the nine values.
- R7: The result of an update is visible on the outputs right after the single clock edge that captures the column.
- R8: Sorted position p occupies bits [p*8 +: 8] of `out_sorted`, and position 0 is the largest value. In `in_col`, row r occupies bits [r*8 +: 8].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset. It asserts asynchronously and is released on a clock edge inside the block |
| in_valid | input | 1 | Accept `in_col` on this edge |
| in_col | input | 24 | Incoming column, three 8-bit pixels |
| out_sorted | output | 72 | Nine sorted pixels, largest at position 0 |
| out_median | output | 8 | Sorted position 4 |
| out_valid | output | 1 | High once three columns have been accepted |

## Verification
The bench builds the block with its default parameters: 8-bit pixels, three rows and three columns. At 8 bits, a short stimulus table can reach both ends of the range (0 and 255), many ties, and a window of nine equal values. With three columns, the fill boundary comes after the third column, and a short run wraps the rotating column tag several times. Both a reset in mid-stream and idle cycles placed between updates are therefore easy to reach.

// File: rtl/wsort_pkg.sv
package wsort_pkg;
  // Number of bits needed to index n items (at least one bit).
  function automatic int idx_bits(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/wsort_col_rank.sv
// Ranks the pixels of the incoming column among themselves.
// Larger values come first; on a tie, the lower row index comes first.
module wsort_col_rank #(
  parameter int W     = 8,
  parameter int ROWS  = 3,
  parameter int POS_W = 4
) (
  input  logic [ROWS*W-1:0]     col,
  output logic [ROWS*POS_W-1:0] rank
);
  logic [POS_W-1:0] r [ROWS];

  always_comb begin
    for (int k = 0; k < ROWS; k++) begin
      r[k] = '0;
      for (int m = 0; m < ROWS; m++) begin
        if (m != k) begin
          if ((col[m*W +: W] > col[k*W +: W]) ||
              ((col[m*W +: W] == col[k*W +: W]) && (m < k))) begin
            r[k] = r[k] + POS_W'(1);
          end
        end
      end
    end
  end

  for (genvar k = 0; k < ROWS; k++) begin : g_out
    assign rank[k*POS_W +: POS_W] = r[k];
  end
endmodule

// File: rtl/wsort_slot_place.sv
// New position of stored slot IDX if it survives the update:
// the survivors ahead of it plus the incoming pixels strictly larger than it.
module wsort_slot_place #(
  parameter int W     = 8,
  parameter int N     = 9,
  parameter int ROWS  = 3,
  parameter int POS_W = 4,
  parameter int IDX   = 0
) (
  input  logic [N-1:0]      keep,
  input  logic [W-1:0]      own_val,
  input  logic [ROWS*W-1:0] col,
  output logic [POS_W-1:0]  dest
);
  always_comb begin
    dest = '0;
    for (int j = 0; j < IDX; j++) begin
      if (keep[j]) dest = dest + POS_W'(1);
    end
    for (int k = 0; k < ROWS; k++) begin
      if (col[k*W +: W] > own_val) dest = dest + POS_W'(1);
    end
  end
endmodule

// File: rtl/wsort_new_place.sv
// Position of one incoming pixel: its rank within the column plus the
// survivors that are greater than or equal to it (older entries win ties).
module wsort_new_place #(
  parameter int W     = 8,
  parameter int N     = 9,
  parameter int POS_W = 4
) (
  input  logic [N-1:0]     keep,
  input  logic [N*W-1:0]   vals,
  input  logic [W-1:0]     new_val,
  input  logic [POS_W-1:0] col_rank,
  output logic [POS_W-1:0] dest
);
  always_comb begin
    dest = col_rank;
    for (int j = 0; j < N; j++) begin
      if (keep[j] && (vals[j*W +: W] >= new_val)) dest = dest + POS_W'(1);
    end
  end
endmodule

// File: rtl/wsort_win3x3.sv
module wsort_win3x3 #(
  parameter int DATA_W = 8,
  parameter int ROWS   = 3,
  parameter int COLS   = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic [ROWS*DATA_W-1:0]        in_col,
  output logic [ROWS*COLS*DATA_W-1:0]   out_sorted,
  output logic [DATA_W-1:0]             out_median,
  output logic                          out_valid
);
  import wsort_pkg::*;

  localparam int N      = ROWS * COLS;
  localparam int POS_W  = idx_bits(N);
  localparam int TAG_W  = idx_bits(COLS);
  localparam int FILL_W = idx_bits(COLS + 1);
  localparam int MED    = N / 2;

  // Reset: asserts asynchronously, released on a clock edge.
  logic [1:0] rsync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  // Stored window: value and column tag per sorted slot.
  logic [DATA_W-1:0] val_q [N];
  logic [DATA_W-1:0] val_d [N];
  logic [TAG_W-1:0]  tag_q [N];
  logic [TAG_W-1:0]  tag_d [N];
  logic [TAG_W-1:0]  old_q, old_d;
  logic [FILL_W-1:0] fill_q, fill_d;
  logic              upd_en;

  logic [N-1:0]          keep;
  logic [N*DATA_W-1:0]   vals_flat;
  logic [POS_W-1:0]      sdest [N];
  logic [POS_W-1:0]      ndest [ROWS];
  logic [ROWS*POS_W-1:0] crank;

  assign upd_en = in_valid;

  for (genvar i = 0; i < N; i++) begin : g_slot
    assign keep[i] = (tag_q[i] != old_q);
    assign vals_flat[i*DATA_W +: DATA_W] = val_q[i];
    assign out_sorted[i*DATA_W +: DATA_W] = val_q[i];

    wsort_slot_place #(
      .W(DATA_W), .N(N), .ROWS(ROWS), .POS_W(POS_W), .IDX(i)
    ) u_place (
      .keep    (keep),
      .own_val (val_q[i]),
      .col     (in_col),
      .dest    (sdest[i])
    );
  end

  wsort_col_rank #(
    .W(DATA_W), .ROWS(ROWS), .POS_W(POS_W)
  ) u_col_rank (
    .col  (in_col),
    .rank (crank)
  );

  for (genvar k = 0; k < ROWS; k++) begin : g_new
    wsort_new_place #(
      .W(DATA_W), .N(N), .POS_W(POS_W)
    ) u_new (
      .keep     (keep),
      .vals     (vals_flat),
      .new_val  (in_col[k*DATA_W +: DATA_W]),
      .col_rank (crank[k*POS_W +: POS_W]),
      .dest     (ndest[k])
    );
  end

  // Next state: each target slot picks the single source whose place matches it.
  always_comb begin
    for (int j = 0; j < N; j++) begin
      val_d[j] = val_q[j];
      tag_d[j] = tag_q[j];
      for (int i = 0; i < N; i++) begin
        if (keep[i] && (sdest[i] == POS_W'(j))) begin
          val_d[j] = val_q[i];
          tag_d[j] = tag_q[i];
        end
      end
      for (int k = 0; k < ROWS; k++) begin
        if (ndest[k] == POS_W'(j)) begin
          val_d[j] = in_col[k*DATA_W +: DATA_W];
          tag_d[j] = old_q;
        end
      end
    end
    old_d  = (old_q == TAG_W'(COLS - 1)) ? '0 : old_q + TAG_W'(1);
    fill_d = (fill_q == FILL_W'(COLS)) ? fill_q : fill_q + FILL_W'(1);
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      for (int i = 0; i < N; i++) begin
        val_q[i] <= '0;
        tag_q[i] <= TAG_W'(i / ROWS);
      end
      old_q  <= '0;
      fill_q <= '0;
    end else if (upd_en) begin
      for (int i = 0; i < N; i++) begin
        val_q[i] <= val_d[i];
        tag_q[i] <= tag_d[i];
      end
      old_q  <= old_d;
      fill_q <= fill_d;
    end
  end

  assign out_median = val_q[MED];
  assign out_valid  = (fill_q == FILL_W'(COLS));
endmodule

// File: rtl/wsort_win3x3_chk.sv
module wsort_win3x3_chk #(
  parameter int DATA_W = 8,
  parameter int ROWS   = 3,
  parameter int COLS   = 3
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        in_valid,
  input logic [ROWS*DATA_W-1:0]      in_col,
  input logic [ROWS*COLS*DATA_W-1:0] out_sorted,
  input logic                        out_valid
);
  localparam int N = ROWS * COLS;

  for (genvar p = 0; p < N - 1; p++) begin : g_ord
    AST_SORTED_DESC: assert property (@(posedge clk) disable iff (!rst_n)
      out_sorted[p*DATA_W +: DATA_W] >= out_sorted[(p+1)*DATA_W +: DATA_W]); // R3
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_new
    AST_NEW_BELOW_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_sorted[0 +: DATA_W] >= $past(in_col[r*DATA_W +: DATA_W])); // R2
    AST_NEW_ABOVE_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_sorted[(N-1)*DATA_W +: DATA_W] <= $past(in_col[r*DATA_W +: DATA_W])); // R2
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_sorted)); // R4

  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> out_valid); // R5

  AST_VALID_ON_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid)); // R5
endmodule

bind wsort_win3x3 wsort_win3x3_chk #(
  .DATA_W(DATA_W), .ROWS(ROWS), .COLS(COLS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_col     (in_col),
  .out_sorted (out_sorted),
  .out_valid  (out_valid)
);

// File: tb/wsort_win3x3_tb.sv
module wsort_win3x3_tb;
  localparam int W    = 8;
  localparam int ROWS = 3;
  localparam int COLS = 3;
  localparam int N    = ROWS * COLS;

  logic              clk;
  logic              rst_n;
  logic              in_valid;
  logic [ROWS*W-1:0] in_col;
  logic [N*W-1:0]    out_sorted;
  logic [W-1:0]      out_median;
  logic              out_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Reference window: hist[0] is the newest column.
  logic [W-1:0] hist [COLS][ROWS];
  int           fillc;

  // {valid, row2, row1, row0}
  localparam logic [ROWS*W:0] VEC [16] = '{
    {1'b1, 8'd10,  8'd200, 8'd30 },
    {1'b1, 8'd5,   8'd5,   8'd5  },
    {1'b1, 8'd255, 8'd0,   8'd128},
    {1'b1, 8'd30,  8'd10,  8'd200},
    {1'b0, 8'd99,  8'd99,  8'd99 },
    {1'b1, 8'd128, 8'd128, 8'd1  },
    {1'b1, 8'd0,   8'd0,   8'd0  },
    {1'b1, 8'd255, 8'd255, 8'd254},
    {1'b0, 8'd7,   8'd8,   8'd9  },
    {1'b1, 8'd64,  8'd32,  8'd16 },
    {1'b1, 8'd16,  8'd32,  8'd64 },
    {1'b1, 8'd200, 8'd200, 8'd200},
    {1'b1, 8'd1,   8'd2,   8'd3  },
    {1'b1, 8'd100, 8'd150, 8'd50 },
    {1'b1, 8'd150, 8'd50,  8'd100},
    {1'b1, 8'd77,  8'd77,  8'd78 }
  };

  wsort_win3x3 #(.DATA_W(W), .ROWS(ROWS), .COLS(COLS)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_col     (in_col),
    .out_sorted (out_sorted),
    .out_median (out_median),
    .out_valid  (out_valid)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic model_clear();
    for (int c = 0; c < COLS; c++)
      for (int r = 0; r < ROWS; r++) hist[c][r] = '0;
    fillc = 0;
  endtask

  task automatic model_push(input logic [ROWS*W-1:0] c);
    for (int k = COLS - 1; k > 0; k--)
      for (int r = 0; r < ROWS; r++) hist[k][r] = hist[k-1][r];
    for (int r = 0; r < ROWS; r++) hist[0][r] = c[r*W +: W];
    if (fillc < COLS) fillc++;
  endtask

  task automatic check_out(input string req);
    int a [N];
    int t;
    logic [N*W-1:0] exp_flat;
    logic [W-1:0]   exp_med;
    logic           exp_v;
    for (int c = 0; c < COLS; c++)
      for (int r = 0; r < ROWS; r++) a[c*ROWS + r] = int'(hist[c][r]);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N - 1 - i; j++)
        if (a[j] < a[j+1]) begin t = a[j]; a[j] = a[j+1]; a[j+1] = t; end
    for (int p = 0; p < N; p++) exp_flat[p*W +: W] = W'(a[p]);
    exp_med = W'(a[4]);
    exp_v   = (fillc >= COLS);
    checks++;
    if (out_sorted !== exp_flat || out_median !== exp_med || out_valid !== exp_v) begin
      fails++;
      $display("FAIL %s: sorted=%h med=%0d valid=%b expected sorted=%h med=%0d valid=%b",
               req, out_sorted, out_median, out_valid, exp_flat, exp_med, exp_v);
    end
  endtask

  // Inputs are driven at a falling edge; the outputs are checked one falling edge later.
  task automatic push(input logic v, input logic [ROWS*W-1:0] c);
    in_valid = v;
    in_col   = c;
    @(negedge clk);
    if (v) model_push(c);
    in_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_col   = '0;
    model_clear();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_col   = '0;
    do_reset();
    check_out("R1 reset state");

    // Stimulus table
    for (int i = 0; i < 16; i++) begin
      push(VEC[i][ROWS*W], VEC[i][ROWS*W-1:0]);
      check_out(VEC[i][ROWS*W] ? "R2 R3 R6 R7 R8 table update" : "R4 table idle");
    end

    // Idle with a changing column has no effect
    push(1'b0, {8'd255, 8'd255, 8'd255});
    check_out("R4 idle with max column");
    push(1'b0, {8'd0, 8'd0, 8'd0});
    check_out("R4 idle with min column");

    // Reset in mid-stream, then the fill boundary
    do_reset();
    check_out("R1 reset after stream");
    push(1'b1, {8'd9, 8'd8, 8'd7});
    check_out("R5 first column, not valid");
    push(1'b0, {8'd1, 8'd1, 8'd1});
    check_out("R5 idle does not count");
    push(1'b1, {8'd6, 8'd250, 8'd4});
    check_out("R5 second column, not valid");
    push(1'b1, {8'd3, 8'd2, 8'd1});
    check_out("R5 third column, valid");
    push(1'b1, {8'd180, 8'd180, 8'd180});
    check_out("R5 R2 stays valid, oldest retired");

    // All nine equal, then a single outlier
    for (int i = 0; i < 3; i++) begin
      push(1'b1, {8'd42, 8'd42, 8'd42});
      check_out("R3 all equal window");
    end
    push(1'b1, {8'd42, 8'd43, 8'd42});
    check_out("R6 R3 one outlier above ties");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule